// File: doc/BRIEF.md
# Decimating Averaging Channel Formatter

This block feeds one output channel of a sample acquisition path. A 5-bit selector picks one of up to thirty parallel 32-bit sample lanes, a free-running test counter, or nothing at all. The selected sample is then narrowed and extended at a programmable bit position, either signed or unsigned. The result is down-sampled by a programmable divisor. The block can either pick one sample per window or average the whole window by accumulating it and shifting the sum. It emits 32-bit words, one per kept sample, or one word per pair of 16-bit samples, on a valid/data pair for the framer that follows.

All lanes share one sample strobe. The configuration inputs are static while the block runs; software changes them while reset is held. Framing and triggering are done downstream.

Top module: `chan_decimator`

## Requirements
- R1: The selector value 0 gives no output. The value 1 selects the test counter. A value s from 2 to NUM_IN+1 selects lane s-2, where lane i is bits [32i+31:32i] of the lane bus. Any larger value behaves like 0.
- R2: With averaging off and 32-bit mode, the effective divisor D is the divisor input, with 0 read as 1. The block outputs the first strobed sample after reset and then every D-th strobed sample after it, unchanged apart from R5.
- R3: With averaging on, the window is W = 2^k, where k is floor(log2 D) capped at 12. At the W-th sample of each window the block outputs the window's sum shifted right by k and restarts the sum. The sum is held in an accumulator 13 bits wider than a sample, so it cannot overflow.
- R4: With averaging on and signed data, the sum is signed and the shift is arithmetic, which rounds toward minus infinity.
- R5: Let p be the extension position. In signed mode every bit above p is replaced by bit p. In unsigned mode every bit above p is cleared. Bits at p and below pass unchanged.
- R6: In 16-bit mode p is capped at 15. Two consecutive kept samples form one word: the earlier in bits [15:0], the later in bits [31:16].
- R7: In 16-bit mode with averaging off, an odd divisor greater than 1 is used as D-1.
- R8: In test mode the kept sample is a counter that is zero after reset and rises by one for each kept sample. In 16-bit mode its low 16 bits are used. The window rules of R2, R3 and R7 still decide which strobes keep a sample.
- R9: out_valid rises in the cycle after the strobe that completes an output word. It is never high in the cycle after a cycle with no strobe.
- R10: While reset is high, out_valid is low in the following cycle, and all counters, sums and pairing state return to their initial values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 5 | Source selector (R1) |
| div_rate | input | 16 | Decimation divisor |
| avg_en | input | 1 | 1 = average each window |
| half_mode | input | 1 | 0 = 32-bit samples, 1 = packed 16-bit samples |
| sgn | input | 1 | 0 = unsigned, 1 = signed |
| ext_pos | input | 5 | Bit position of the sign or zero extension |
| smp_valid | input | 1 | Common sample strobe for all lanes |
| lanes | input | 960 | Thirty 32-bit sample lanes, lane 0 in the low bits |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 32 | Output word |

## Verification
The hardest case to reach is a full averaging window of 4096 signed or unsigned samples whose shifted sum must come out exact. Right behind it are the pairing of 16-bit results that fall across window boundaries, and strobe gaps in the middle of a window. The bench reaches these by sweeping all 32 selector codes and a set of divisor, averaging, width and extension settings. It puts a sample gap every few strobes and runs 8192 samples at the largest window. A cycle-stamped queue of expected words, built from the requirements, checks each word's value and its exact output cycle.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

    localparam int SMP_W  = 32;
    localparam int HALF_W = 16;
    localparam int SEL_W  = 5;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TEST = 2'd1,
        SRC_LANE = 2'd2
    } src_e;

    typedef struct packed {
        logic       avg_en;
        logic       half;
        logic       sgn;
        logic [4:0] pos;
    } fmt_t;

    // Narrow to bit p and extend above it (sign copy or zero fill).
    function automatic logic [SMP_W-1:0] condition(input logic [SMP_W-1:0] x,
                                                   input fmt_t f);
        logic [4:0]       p;
        logic [SMP_W-1:0] keep;
        p    = (f.half && f.pos > 5'd15) ? 5'd15 : f.pos;
        keep = (p == 5'd31) ? '1 : ((SMP_W'(1) << (p + 5'd1)) - SMP_W'(1));
        return (f.sgn && x[p]) ? (x | ~keep) : (x & keep);
    endfunction

    // floor(log2(d)) capped at lim; d = 0 yields 0.
    function automatic int log2_cap(input logic [31:0] d, input int lim);
        int k;
        k = 0;
        for (int i = 0; i < 32; i++) begin
            if (d[i]) k = i;
        end
        if (k > lim) k = lim;
        return k;
    endfunction

endpackage

// File: rtl/cdec_source_sel.sv
module cdec_source_sel
    import cdec_pkg::*;
#(
    parameter int NUM_IN = 30
) (
    input  logic [SEL_W-1:0]        sel,
    input  logic [NUM_IN*SMP_W-1:0] lanes,
    output src_e                    src,
    output logic [SMP_W-1:0]        raw
);
    logic [SMP_W-1:0] lane_arr [NUM_IN];

    for (genvar g = 0; g < NUM_IN; g++) begin : g_unpack
        assign lane_arr[g] = lanes[g*SMP_W +: SMP_W];
    end

    always_comb begin
        src = SRC_NONE;
        raw = '0;
        if (sel == SEL_W'(1)) begin
            src = SRC_TEST;
        end
        for (int i = 0; i < NUM_IN; i++) begin
            if (int'(sel) == i + 2) begin
                src = SRC_LANE;
                raw = lane_arr[i];
            end
        end
    end
endmodule

// File: rtl/cdec_decimator.sv
module cdec_decimator
    import cdec_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int AVG_LOG_MAX = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  src_e             src,
    input  logic [SMP_W-1:0] sample,
    input  fmt_t             fmt,
    input  logic [DIV_W-1:0] div_rate,
    output logic             fire,
    output logic [SMP_W-1:0] value
);
    localparam int ACC_W = SMP_W + AVG_LOG_MAX + 1;

    logic [DIV_W-1:0] cnt_q, d_eff, win;
    logic [ACC_W-1:0] acc_q, ext, sum;
    logic [SMP_W-1:0] tcnt_q, avg_out;
    logic             active, last;
    int               k;

    always_comb begin
        d_eff  = (div_rate == '0) ? DIV_W'(1) : div_rate;
        k      = log2_cap(32'(d_eff), AVG_LOG_MAX);
        if (fmt.avg_en)
            win = DIV_W'(1) << k;
        else if (fmt.half && d_eff[0] && d_eff != DIV_W'(1))
            win = d_eff - DIV_W'(1);
        else
            win = d_eff;
        last    = (cnt_q == win - DIV_W'(1));
        active  = smp_valid && (src != SRC_NONE);
        ext     = fmt.sgn ? {{(ACC_W-SMP_W){sample[SMP_W-1]}}, sample}
                          : {{(ACC_W-SMP_W){1'b0}}, sample};
        sum     = acc_q + ext;
        avg_out = fmt.sgn ? SMP_W'($signed(sum) >>> k) : SMP_W'(sum >> k);
        fire    = active && (fmt.avg_en ? last : (cnt_q == '0));
        if (src == SRC_TEST)
            value = tcnt_q;
        else
            value = fmt.avg_en ? avg_out : sample;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            tcnt_q <= '0;
        end else if (active) begin
            cnt_q <= last ? '0 : cnt_q + DIV_W'(1);
            if (fmt.avg_en)
                acc_q <= last ? '0 : sum;
            if (fire && src == SRC_TEST)
                tcnt_q <= tcnt_q + SMP_W'(1);
        end
    end
endmodule

// File: rtl/cdec_packer.sv
module cdec_packer
    import cdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             half,
    input  logic             fire,
    input  logic [SMP_W-1:0] value,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_data
);
    logic              phase_q;
    logic [HALF_W-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= 1'b0;
            low_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (fire) begin
                if (!half) begin
                    out_valid <= 1'b1;
                    out_data  <= value;
                end else if (!phase_q) begin
                    low_q   <= value[HALF_W-1:0];
                    phase_q <= 1'b1;
                end else begin
                    out_valid <= 1'b1;
                    out_data  <= {value[HALF_W-1:0], low_q};
                    phase_q   <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/chan_decimator.sv
module chan_decimator
    import cdec_pkg::*;
#(
    parameter int NUM_IN      = 30,
    parameter int DIV_W       = 16,
    parameter int AVG_LOG_MAX = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SEL_W-1:0]        sel,
    input  logic [DIV_W-1:0]        div_rate,
    input  logic                    avg_en,
    input  logic                    half_mode,
    input  logic                    sgn,
    input  logic [4:0]              ext_pos,
    input  logic                    smp_valid,
    input  logic [NUM_IN*SMP_W-1:0] lanes,
    output logic                    out_valid,
    output logic [SMP_W-1:0]        out_data
);
    fmt_t             fmt;
    src_e             src;
    logic [SMP_W-1:0] raw, cond;
    logic             fire;
    logic [SMP_W-1:0] value;

    assign fmt  = '{avg_en: avg_en, half: half_mode, sgn: sgn, pos: ext_pos};
    assign cond = condition(raw, fmt);

    cdec_source_sel #(.NUM_IN(NUM_IN)) u_sel (
        .sel   (sel),
        .lanes (lanes),
        .src   (src),
        .raw   (raw)
    );

    cdec_decimator #(.DIV_W(DIV_W), .AVG_LOG_MAX(AVG_LOG_MAX)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .src       (src),
        .sample    (cond),
        .fmt       (fmt),
        .div_rate  (div_rate),
        .fire      (fire),
        .value     (value)
    );

    cdec_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .half      (half_mode),
        .fire      (fire),
        .value     (value),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/chan_decimator_checker.sv
module chan_decimator_checker #(
    parameter int NUM_IN = 30,
    parameter int DIV_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [4:0]        sel,
    input logic [DIV_W-1:0]  div_rate,
    input logic              avg_en,
    input logic              half_mode,
    input logic              smp_valid,
    input logic              out_valid,
    input logic [31:0]       out_data
);
    logic [31:0] prev_q;
    logic        have_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            have_q <= 1'b0;
        end else if (out_valid) begin
            prev_q <= out_data;
            have_q <= 1'b1;
        end
    end

    assert_reset_quiet_R10: assert property (@(posedge clk) rst |=> !out_valid);

    assert_no_strobe_no_word_R9: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !out_valid);

    assert_disabled_silent_R1: assert property (@(posedge clk) disable iff (rst)
        (sel == 5'd0) |=> !out_valid);

    assert_full_rate_R2: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && sel != 5'd0 && int'(sel) <= NUM_IN + 1 &&
         div_rate <= DIV_W'(1) && !avg_en && !half_mode) |=> out_valid);

    assert_test_step_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && have_q && sel == 5'd1 && !half_mode) |-> out_data == prev_q + 32'd1);
endmodule

bind chan_decimator chan_decimator_checker #(.NUM_IN(NUM_IN), .DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .div_rate  (div_rate),
    .avg_en    (avg_en),
    .half_mode (half_mode),
    .smp_valid (smp_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/chan_decimator_bench.sv
module chan_decimator_bench;
    localparam int NUM_IN = 30;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [4:0]           sel = '0;
    logic [15:0]          div_rate = '0;
    logic                 avg_en = 1'b0, half_mode = 1'b0, sgn = 1'b0;
    logic [4:0]           ext_pos = '0;
    logic                 smp_valid = 1'b0;
    logic [NUM_IN*32-1:0] lanes = '0;
    logic                 out_valid;
    logic [31:0]          out_data;

    int    cyc = 0, n_checks = 0, n_bad = 0;
    bit    done = 0;
    string cur_tag = "R10";
    logic [31:0] exp_q[$];
    int          exp_t[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    chan_decimator u_chan_decimator (
        .clk(clk), .rst(rst), .sel(sel), .div_rate(div_rate), .avg_en(avg_en),
        .half_mode(half_mode), .sgn(sgn), .ext_pos(ext_pos), .smp_valid(smp_valid),
        .lanes(lanes), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [31:0] raw_of(int ch, int idx);
        return 32'(idx) * 32'h9E37_79B1 + 32'(ch) * 32'h0100_0193 + 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] ext_of(logic [31:0] x, int p, bit s);
        logic [31:0] r;
        for (int b = 0; b < 32; b++) r[b] = (b > p) ? (s & x[p]) : x[b];
        return r;
    endfunction

    // monitor: every word must match the queue head in value and cycle
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL %s: unexpected word %h at cycle %0d, expected none",
                         cur_tag, out_data, cyc);
            end else begin
                logic [31:0] ev; int et;
                ev = exp_q.pop_front();
                et = exp_t.pop_front();
                if (ev !== out_data || et != cyc) begin
                    n_bad++;
                    $display("FAIL %s (R9 timing): word %h cycle %0d, expected %h cycle %0d",
                             cur_tag, out_data, cyc, ev, et);
                end
            end
        end
    end

    task automatic run_cfg(string tag, int s, int dv, bit av, bit hf, bit sg, int ps, int n);
        int d, k, w, cnt, p, ch;
        longint acc;
        logic [31:0] tcnt, lowv, x, v;
        bit phase, fire;
        cur_tag = tag;
        @(negedge clk);
        rst = 1'b1; smp_valid = 1'b0;
        sel = 5'(s); div_rate = 16'(dv); avg_en = av; half_mode = hf;
        sgn = sg; ext_pos = 5'(ps);
        repeat (2) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: out_valid %b under reset, expected 0", out_valid);
        end
        rst = 1'b0;
        d = (dv == 0) ? 1 : dv;
        k = 0;
        for (int i = 0; i < 16; i++) if ((d >> i) & 1) k = i;
        if (k > 12) k = 12;
        if (av) w = 1 << k;
        else if (hf && d > 1 && (d % 2 == 1)) w = d - 1;   // R7
        else w = d;
        p = (hf && ps > 15) ? 15 : ps;
        ch = s - 2;
        cnt = 0; acc = 0; tcnt = 0; lowv = 0; phase = 0;
        for (int idx = 0; idx < n; idx++) begin
            if (idx % 5 == 3) begin
                smp_valid = 1'b0;
                @(negedge clk);
            end
            for (int c = 0; c < NUM_IN; c++) lanes[c*32 +: 32] = raw_of(c, idx);
            smp_valid = 1'b1;
            fire = 0;
            v = '0;
            if (s != 0 && s <= NUM_IN + 1) begin
                x = (s == 1) ? 32'h0 : ext_of(raw_of(ch, idx), p, sg);
                if (av) begin
                    acc = acc + (sg ? longint'($signed(x)) : longint'({32'h0, x}));
                    cnt++;
                    if (cnt == w) begin
                        fire = 1; v = 32'(acc >>> k); acc = 0; cnt = 0;
                    end
                end else begin
                    fire = (cnt == 0);
                    v = x;
                    cnt = (cnt + 1 == w) ? 0 : cnt + 1;
                end
                if (fire && s == 1) begin
                    v = tcnt; tcnt++;
                end
                if (fire) begin
                    if (!hf) begin
                        exp_q.push_back(v); exp_t.push_back(cyc + 1);
                    end else if (!phase) begin
                        lowv = {16'h0, v[15:0]}; phase = 1;
                    end else begin
                        exp_q.push_back({v[15:0], lowv[15:0]}); exp_t.push_back(cyc + 1);
                        phase = 0;
                    end
                end
            end
            @(negedge clk);
        end
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL %s: %0d words missing, expected 0", tag, exp_q.size());
            exp_q.delete(); exp_t.delete();
        end
    endtask

    initial begin
        // R1: every selector code, full rate, 32-bit, no extension
        for (int s = 0; s < 32; s++) run_cfg("R1", s, 1, 0, 0, 0, 31, 12);
        // R2: non-averaged decimation, 32-bit
        run_cfg("R2", 5, 0, 0, 0, 0, 31, 20);
        run_cfg("R2", 5, 3, 0, 0, 1, 31, 30);
        run_cfg("R2", 29, 7, 0, 0, 0, 31, 40);
        // R3: averaging, unsigned, incl. non power of two and the largest window
        run_cfg("R3", 9, 1, 1, 0, 0, 31, 20);
        run_cfg("R3", 9, 4, 1, 0, 0, 31, 48);
        run_cfg("R3", 9, 6, 1, 0, 0, 31, 48);
        run_cfg("R3", 3, 16'hFFFF, 1, 0, 0, 15, 8192);
        // R4: averaging, signed
        run_cfg("R4", 12, 8, 1, 0, 1, 31, 48);
        run_cfg("R4", 12, 2, 1, 0, 1, 9, 30);
        // R5: extension position, signed and unsigned
        run_cfg("R5", 20, 1, 0, 0, 1, 0, 20);
        run_cfg("R5", 20, 1, 0, 0, 1, 7, 20);
        run_cfg("R5", 20, 1, 0, 0, 1, 20, 20);
        run_cfg("R5", 21, 1, 0, 0, 0, 7, 20);
        run_cfg("R5", 21, 1, 0, 0, 0, 30, 20);
        // R6: 16-bit packing
        run_cfg("R6", 7, 1, 0, 1, 1, 15, 24);
        run_cfg("R6", 7, 1, 0, 1, 0, 20, 24);
        run_cfg("R6", 8, 4, 0, 1, 1, 11, 40);
        run_cfg("R6", 8, 8, 1, 1, 1, 15, 80);
        // R7: odd divisors in 16-bit non-averaged mode
        run_cfg("R7", 30, 3, 0, 1, 0, 15, 30);
        run_cfg("R7", 31, 5, 0, 1, 1, 15, 40);
        // R8: test counter under several cadences
        run_cfg("R8", 1, 1, 0, 0, 0, 31, 20);
        run_cfg("R8", 1, 3, 0, 0, 1, 31, 30);
        run_cfg("R8", 1, 4, 1, 0, 0, 31, 40);
        run_cfg("R8", 1, 1, 0, 1, 0, 15, 20);
        run_cfg("R8", 1, 2, 1, 1, 1, 15, 30);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: run still active, expected completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule